// File: doc/BRIEF.md
# Four-State Soft-Decision Add-Compare-Select Stage

This block performs one trellis iteration of a four-state, rate-1/2 Viterbi processor in a single clock cycle. It takes two soft channel symbols and the four state metrics left by the previous iteration. From the symbols it forms the four branch metrics. It then runs four two-way add-compare-select operations, arranged as two butterflies. It registers the four updated state metrics together with a 1-bit survivor decision for each state.

A single parameter selects the trellis direction. In forward mode each state is updated from its two predecessors. In backward mode the trellis is reversed, so each state is updated from its two successors. This allows the same stage to sit in a forward-running or a backward-running chain of stages.

State metrics are never normalized. They wrap modulo 2^SM_W, and every comparison uses the sign of a wraparound difference. The block has no flow control. An input valid flag loads the stage register, and the flag is carried to the output alongside the data.

Top module: `vit_acs_stage`

## Requirements
- R1: For soft symbol y (0..7, where 0 is a confident logic 0), the per-symbol distance is y against an expected 0 and 7-y against an expected 1. The branch metric for the code pair (c0,c1) is the sum of the two distances (sym0_i against c0, sym1_i against c1). It is 4 bits wide and is indexed 2*c0+c1.
- R2: A state is the 2-bit shift register {p1,p0}, with p1 the newest bit. Input bit u moves state {p1,p0} to {u,p1} and emits c0 = u^p1^p0 and c1 = u^p0.
- R3: With DIR = TRELLIS_FWD, metric_o[s] is the smaller of metric_i[p]+bm over the predecessors p = 2*(s mod 2) and 2*(s mod 2)+1. decision_o[s] equals bit 0 of the winning predecessor.
- R4: With DIR = TRELLIS_BWD, metric_o[p] is the smaller of metric_i[s]+bm over the successors s = p div 2 and p div 2 + 2. decision_o[p] equals bit 1 of the winning successor, which is the input bit u.
- R5: Additions wrap modulo 128 (SM_W = 7). The comparison picks the true smaller sum whenever the two candidates are less than 64 apart, including when the sums cross the wrap point.
- R6: When the two candidates are equal, the lower-numbered candidate wins and the decision is 0.
- R7: The stage has exactly one register level. A result computed from inputs presented with valid_i = 1 appears on metric_o and decision_o after the next rising clock edge, with valid_o = 1. The outputs do not change before that edge.
- R8: While valid_i = 0, metric_o and decision_o hold their values whatever sym0_i, sym1_i and metric_i do, and valid_o is 0 after the next edge.
- R9: While rst_ni is low, valid_o, metric_o and decision_o are all zero, even with valid_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry an iteration to process |
| sym0_i | input | 3 | Soft symbol compared with c0 |
| sym1_i | input | 3 | Soft symbol compared with c1 |
| metric_i | input | 4x7 | Incoming state metrics, element n for state n |
| valid_o | output | 1 | Registered valid flag |
| metric_o | output | 4x7 | Updated state metrics, element n for state n |
| decision_o | output | 4 | Survivor decision per updated state |

## Verification
A wrong branch metric, wrong trellis wiring or wrong compare sign shows up at the ports on the first edge after a valid input. It appears as a metric or decision that differs from the minimum computed directly from the shift-register trellis definition. A fault in the wraparound compare stays hidden until the candidate sums straddle the modulo boundary, so some stimulus vectors place the metrics just below 128. A broken load enable is visible only when valid_i falls, through outputs that move while they should hold.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned NUM_FLY    = NUM_STATES / 2;

  typedef enum logic {
    TRELLIS_FWD = 1'b0,
    TRELLIS_BWD = 1'b1
  } trellis_dir_e;

  // Branch label index {c0,c1} for the butterfly edge between candidate j
  // and target t of butterfly k; identical in both directions.
  function automatic int unsigned edge_code(int unsigned t, int unsigned k, int unsigned j);
    int unsigned c0;
    int unsigned c1;
    c0 = (t ^ k ^ j) & 1;
    c1 = (t ^ j) & 1;
    return c0 * 2 + c1;
  endfunction

endpackage

// File: rtl/vit_bm_unit.sv
module vit_bm_unit import vit_acs_pkg::*; #(
  parameter int unsigned SOFT_W = 3,
  localparam int unsigned BM_W  = SOFT_W + 1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [SOFT_W-1:0]                    sym0_i,
  input  logic [SOFT_W-1:0]                    sym1_i,
  output logic [NUM_STATES-1:0][BM_W-1:0]      bm_o
);

  localparam int unsigned FULL = (1 << SOFT_W) - 1;

  for (genvar c = 0; c < NUM_STATES; c++) begin : g_code
    localparam bit EXP0 = ((c >> 1) & 1) != 0;
    localparam bit EXP1 = (c & 1) != 0;
    logic [SOFT_W-1:0] dist0;
    logic [SOFT_W-1:0] dist1;
    assign dist0   = EXP0 ? ~sym0_i : sym0_i;
    assign dist1   = EXP1 ? ~sym1_i : sym1_i;
    assign bm_o[c] = BM_W'(dist0) + BM_W'(dist1);
  end

  // Opposite labels always sum to twice full scale (R1)
  p_bm_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((BM_W+1)'(bm_o[0]) + (BM_W+1)'(bm_o[3]) == (BM_W+1)'(2*FULL)) &&
    ((BM_W+1)'(bm_o[1]) + (BM_W+1)'(bm_o[2]) == (BM_W+1)'(2*FULL)));

endmodule

// File: rtl/vit_acs2.sv
module vit_acs2 #(
  parameter int unsigned SM_W = 7,
  parameter int unsigned BM_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SM_W-1:0] metric_a_i,
  input  logic [BM_W-1:0] bm_a_i,
  input  logic [SM_W-1:0] metric_b_i,
  input  logic [BM_W-1:0] bm_b_i,
  output logic [SM_W-1:0] metric_o,
  output logic            dec_o
);

  logic [SM_W-1:0] sum_a;
  logic [SM_W-1:0] sum_b;
  logic [SM_W-1:0] diff;
  logic            take_b;

  assign sum_a  = metric_a_i + SM_W'(bm_a_i);
  assign sum_b  = metric_b_i + SM_W'(bm_b_i);
  // a - b positive and nonzero means b is smaller; ties keep a
  assign diff   = sum_a - sum_b;
  assign take_b = !diff[SM_W-1] && (diff != '0);

  assign metric_o = take_b ? sum_b : sum_a;
  assign dec_o    = take_b;

  logic [SM_W-1:0] loser;
  logic [SM_W-1:0] gap;
  assign loser = dec_o ? sum_a : sum_b;
  assign gap   = metric_o - loser;

  p_winner_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap[SM_W-1] || (gap == '0));

  p_tie_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_a == sum_b) |-> !dec_o);

endmodule

// File: rtl/vit_butterfly.sv
module vit_butterfly import vit_acs_pkg::*; #(
  parameter int unsigned SM_W = 7,
  parameter int unsigned BM_W = 4,
  parameter int unsigned IDX  = 0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [1:0][SM_W-1:0]             src_i,
  input  logic [NUM_STATES-1:0][BM_W-1:0]  bm_i,
  output logic [1:0][SM_W-1:0]             dst_o,
  output logic [1:0]                       dec_o
);

  for (genvar t = 0; t < 2; t++) begin : g_tgt
    localparam int unsigned CODE_A = edge_code(t, IDX, 0);
    localparam int unsigned CODE_B = edge_code(t, IDX, 1);

    vit_acs2 #(.SM_W(SM_W), .BM_W(BM_W)) u_acs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .metric_a_i(src_i[0]),
      .bm_a_i    (bm_i[CODE_A]),
      .metric_b_i(src_i[1]),
      .bm_b_i    (bm_i[CODE_B]),
      .metric_o  (dst_o[t]),
      .dec_o     (dec_o[t])
    );
  end

endmodule

// File: rtl/vit_acs_stage.sv
module vit_acs_stage import vit_acs_pkg::*; #(
  parameter int unsigned  SOFT_W = 3,
  parameter int unsigned  SM_W   = 7,
  parameter trellis_dir_e DIR    = TRELLIS_FWD
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic [SOFT_W-1:0]                sym0_i,
  input  logic [SOFT_W-1:0]                sym1_i,
  input  logic [NUM_STATES-1:0][SM_W-1:0]  metric_i,
  output logic                             valid_o,
  output logic [NUM_STATES-1:0][SM_W-1:0]  metric_o,
  output logic [NUM_STATES-1:0]            decision_o
);

  localparam int unsigned BM_W = SOFT_W + 1;

  logic [NUM_STATES-1:0][BM_W-1:0] bm;
  logic [NUM_STATES-1:0][SM_W-1:0] nxt_metric;
  logic [NUM_STATES-1:0]           nxt_dec;

  vit_bm_unit #(.SOFT_W(SOFT_W)) u_bm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sym0_i(sym0_i),
    .sym1_i(sym1_i),
    .bm_o  (bm)
  );

  for (genvar k = 0; k < NUM_FLY; k++) begin : g_fly
    logic [1:0][SM_W-1:0] fly_src;
    logic [1:0][SM_W-1:0] fly_dst;
    logic [1:0]           fly_dec;

    for (genvar j = 0; j < 2; j++) begin : g_wire
      if (DIR == TRELLIS_FWD) begin : g_fwd
        // sources 2k,2k+1 feed targets k,k+2
        assign fly_src[j]          = metric_i[2*k+j];
        assign nxt_metric[k+2*j]   = fly_dst[j];
        assign nxt_dec[k+2*j]      = fly_dec[j];
      end else begin : g_bwd
        // sources k,k+2 feed targets 2k,2k+1
        assign fly_src[j]          = metric_i[k+2*j];
        assign nxt_metric[2*k+j]   = fly_dst[j];
        assign nxt_dec[2*k+j]      = fly_dec[j];
      end
    end

    vit_butterfly #(.SM_W(SM_W), .BM_W(BM_W), .IDX(k)) u_fly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (fly_src),
      .bm_i  (bm),
      .dst_o (fly_dst),
      .dec_o (fly_dec)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      metric_o   <= '0;
      decision_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        metric_o   <= nxt_metric;
        decision_o <= nxt_dec;
      end
    end
  end

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(metric_o) && $stable(decision_o)));

endmodule

// File: tb/sim_vit_acs_stage.sv
module sim_vit_acs_stage;
  import vit_acs_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            vin;
  logic [2:0]      s0, s1;
  logic [3:0][6:0] min;
  logic            vf, vb;
  logic [3:0][6:0] mf, mb;
  logic [3:0]      df, db;

  vit_acs_stage #(.DIR(TRELLIS_FWD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .sym0_i(s0), .sym1_i(s1),
    .metric_i(min), .valid_o(vf), .metric_o(mf), .decision_o(df));

  vit_acs_stage #(.DIR(TRELLIS_BWD)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .sym0_i(s0), .sym1_i(s1),
    .metric_i(min), .valid_o(vb), .metric_o(mb), .decision_o(db));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // {sym0, sym1, base(9), off0..off3 (6 each)}; true metric = base + off
  localparam int NVEC = 8;
  localparam logic [38:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 9'd0,   6'd0,  6'd0,  6'd0,  6'd0 },
    {3'd7, 3'd7, 9'd10,  6'd0,  6'd3,  6'd9,  6'd1 },
    {3'd3, 3'd4, 9'd100, 6'd20, 6'd0,  6'd5,  6'd30},
    {3'd5, 3'd1, 9'd120, 6'd0,  6'd7,  6'd2,  6'd40},
    {3'd6, 3'd2, 9'd250, 6'd13, 6'd13, 6'd0,  6'd6 },
    {3'd1, 3'd6, 9'd60,  6'd40, 6'd10, 6'd25, 6'd0 },
    {3'd2, 3'd5, 9'd127, 6'd1,  6'd0,  6'd1,  6'd0 },
    {3'd4, 3'd3, 9'd300, 6'd8,  6'd22, 6'd15, 6'd3 }
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int bm_true(int y0, int y1, int c0, int c1);
    return (c0 != 0 ? 7 - y0 : y0) + (c1 != 0 ? 7 - y1 : y1);
  endfunction

  // Reference from the shift-register trellis, using unwrapped integers
  task automatic model(input bit bwd, input int y0, input int y1, input int m[4],
                       output int om[4], output int od[4]);
    for (int tgt = 0; tgt < 4; tgt++) begin
      int cost[2];
      for (int j = 0; j < 2; j++) begin
        int src, u, p1, p0;
        if (!bwd) begin
          src = 2*(tgt%2) + j; u = tgt/2; p1 = tgt%2; p0 = j;
        end else begin
          src = tgt/2 + 2*j;   u = j;     p1 = tgt/2; p0 = tgt%2;
        end
        cost[j] = m[src] + bm_true(y0, y1, u^p1^p0, u^p0);
      end
      od[tgt] = (cost[1] < cost[0]) ? 1 : 0;
      om[tgt] = ((cost[1] < cost[0]) ? cost[1] : cost[0]) % 128;
    end
  endtask

  task automatic run_vec(input int y0, input int y1, input int m[4]);
    int ofm[4], ofd[4], obm[4], obd[4];
    logic [3:0][6:0] prev;
    model(1'b0, y0, y1, m, ofm, ofd);
    model(1'b1, y0, y1, m, obm, obd);
    prev = mf;
    s0 = 3'(y0); s1 = 3'(y1); vin = 1'b1;
    for (int i = 0; i < 4; i++) min[i] = 7'(m[i] % 128);
    #1;
    chk("R7 no change before edge", 32'(mf), 32'(prev));
    @(posedge clk);
    @(negedge clk);
    vin = 1'b0;
    chk("R7 valid_o fwd", 32'(vf), 1);
    chk("R7 valid_o bwd", 32'(vb), 1);
    for (int i = 0; i < 4; i++) begin
      chk("R1 R2 R3 R5 fwd metric", 32'(mf[i]), 32'(ofm[i]));
      chk("R3 R6 fwd decision", 32'(df[i]), 32'(ofd[i]));
      chk("R1 R2 R4 R5 bwd metric", 32'(mb[i]), 32'(obm[i]));
      chk("R4 R6 bwd decision", 32'(db[i]), 32'(obd[i]));
    end
  endtask

  initial begin
    rst_n = 1'b0; vin = 1'b0; s0 = '0; s1 = '0; min = '0;
    repeat (2) @(negedge clk);
    // R9: reset dominates a valid input
    vin = 1'b1; s0 = 3'd5; s1 = 3'd2; min = {7'd9, 7'd3, 7'd40, 7'd1};
    @(negedge clk);
    chk("R9 reset valid_o", 32'({vf, vb}), 0);
    chk("R9 reset metric fwd", 32'(mf), 0);
    chk("R9 reset metric bwd", 32'(mb), 0);
    chk("R9 reset decision", 32'({df, db}), 0);
    vin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int m[4];
      logic [38:0] e;
      e = VEC[v];
      m[0] = int'(e[32:24]) + int'(e[23:18]);
      m[1] = int'(e[32:24]) + int'(e[17:12]);
      m[2] = int'(e[32:24]) + int'(e[11:6]);
      m[3] = int'(e[32:24]) + int'(e[5:0]);
      run_vec(int'(e[38:36]), int'(e[35:33]), m);
    end

    // Hand-worked: zero metrics, confident zeros; ties on states 1,3 (fwd) and 2,3 (bwd)
    begin
      int m[4];
      m = '{0, 0, 0, 0};
      run_vec(0, 0, m);
      chk("R3 R6 fwd hand metric", 32'(mf), 32'({7'd7, 7'd0, 7'd7, 7'd0}));
      chk("R3 R6 fwd hand decision", 32'(df), 32'(4'b0100));
      chk("R4 R6 bwd hand metric", 32'(mb), 32'({7'd7, 7'd7, 7'd0, 7'd0}));
      chk("R4 R6 bwd hand decision", 32'(db), 32'(4'b0010));
    end

    // R5: sums straddle 128 (true 120 vs 141)
    begin
      int m[4];
      m = '{120, 127, 118, 125};
      run_vec(0, 0, m);
      chk("R5 wrap pick fwd state0", 32'(mf[0]), 120);
      chk("R5 wrap decision fwd state0", 32'(df[0]), 0);
    end

    // R8: idle cycles with changing inputs leave the outputs alone
    begin
      logic [3:0][6:0] hf, hb;
      logic [3:0] hdf, hdb;
      hf = mf; hb = mb; hdf = df; hdb = db;
      vin = 1'b0; s0 = 3'd7; s1 = 3'd3; min = {7'd1, 7'd90, 7'd14, 7'd66};
      repeat (3) @(negedge clk);
      chk("R8 hold metric fwd", 32'(mf), 32'(hf));
      chk("R8 hold metric bwd", 32'(mb), 32'(hb));
      chk("R8 hold decision", 32'({df, db}), 32'({hdf, hdb}));
      chk("R8 valid_o low", 32'({vf, vb}), 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule